// File: doc/BRIEF.md
# Neighbour-Routed Programmable Logic Cell

This block is a single tile of a fine-grained programmable array that is itself built from ordinary logic on a host device. It has one signal arriving from each of its four nearest neighbours (north, east, south and west) and drives one signal back toward each of them. The cell has no other inputs and no long-reach connections. All routing is done by the cells themselves, so a signal crosses the array by passing from one tile to the next through each tile's output selectors.

Inside the tile, three operand selectors feed a two-way multiplexer function unit. Each operand selector has eight inputs: the four neighbour inputs, the registered result, the inverse of the registered result, and the constants 0 and 1. The result of the function unit is available both as a combinational value and through a data flip-flop. The flip-flop has a clock enable, a toggle mode and an optional synchronous clear driven by the west input. Each of the four outputs has its own four-way selector. It can pick the combinational result, the registered result, the input from the opposite side, or the input from the next neighbour clockwise.

All 24 configuration bits are held in a serial shift chain. Software-free loading is done by holding the shift enable high and streaming bits in LSB first. The chain's serial output lets many tiles be daisy-chained into one long configuration path.

Top module: `sog_cell`

## Requirements
- R1: While `cfg_en` is high, each rising clock edge shifts `cfg_in` into configuration bit 23 and moves every bit down one place. `cfg_out` always shows configuration bit 0. After 24 shifts, the word sent LSB first occupies bits 0..23, and the previous contents have left through `cfg_out` in the order bit 0 first.
- R2: While `cfg_en` is low, the configuration bits do not change, whatever `rst` or the data inputs do.
- R3: Operand selector k (k = 0, 1, 2) uses configuration bits [3k+2:3k]. The codes are 0 = north input, 1 = east, 2 = south, 3 = west, 4 = registered result q, 5 = inverted q, 6 = constant 0 and 7 = constant 1.
- R4: The combinational result is f = op0 ? op1 : op2.
- R5: The output selector for north, east, south and west uses bits [10:9], [12:11], [14:13] and [16:15] respectively. The codes are 0 = f, 1 = q, 2 = the input from the opposite side, and 3 = the input from the clockwise neighbour (north takes east, east takes south, south takes west, west takes north).
- R6: With `cfg_en` low, no clear and clock enable bit 18 set, a rising edge loads q with f when toggle bit 17 is 0, or with q XOR f when bit 17 is 1. With bit 18 clear, q holds.
- R7: With `cfg_en` low, clear-enable bit 19 set and the west input high, a rising edge clears q. This happens whatever the clock enable is. With bit 19 clear, the west input has no clearing effect.
- R8: While `cfg_en` is high, q holds its value even when a load or a clear would otherwise apply.
- R9: `rst` high at a rising edge clears q, including during shifting. It leaves the configuration bits intact.
- R10: Bits 23:20 are reserved. They have no effect on any output, and they are shifted out on `cfg_out` exactly as they were shifted in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the data flip-flop |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_in | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Serial configuration data out, for chaining |
| in_n | input | 1 | Signal from the north neighbour |
| in_e | input | 1 | Signal from the east neighbour |
| in_s | input | 1 | Signal from the south neighbour |
| in_w | input | 1 | Signal from the west neighbour; also the synchronous clear when enabled |
| out_n | output | 1 | Signal toward the north neighbour |
| out_e | output | 1 | Signal toward the east neighbour |
| out_s | output | 1 | Signal toward the south neighbour |
| out_w | output | 1 | Signal toward the west neighbour |

## Verification
Two collisions on the data flip-flop matter most. The first is a configuration shift in the same cycle as a pending clear or load. The second is a reset in the same cycles as a shift. To provoke the first, a stored 1 is followed by a complete reload with the west input held high and a zero-loading function enabled. The registered output must still read 1 right after shifting ends and drop to 0 one edge later. The second is provoked by holding reset through an entire load. It is judged by q reading 0 afterwards and by the next load's serial readback returning the word intact.

// File: rtl/sog_pkg.sv
package sog_pkg;
  localparam int NDIR    = 4;
  localparam int SEL_W   = 3;
  localparam int NOPS    = 3;
  localparam int RT_W    = 2;
  localparam int RSV_W   = 4;
  localparam int OPF_W   = NOPS * SEL_W;
  localparam int RTF_W   = NDIR * RT_W;
  localparam int RT_LSB  = OPF_W;
  localparam int TOG_BIT = RT_LSB + RTF_W;
  localparam int CE_BIT  = TOG_BIT + 1;
  localparam int CLR_BIT = CE_BIT + 1;
  localparam int USED_W  = CLR_BIT + 1;
  localparam int CFG_W   = USED_W + RSV_W;

  typedef enum logic [1:0] {
    RT_FUNC = 2'd0,
    RT_REG  = 2'd1,
    RT_OPP  = 2'd2,
    RT_CW   = 2'd3
  } route_e;
endpackage

// File: rtl/sog_cfg_chain.sv
module sog_cfg_chain #(
  parameter int CHAIN_W = 24,
  parameter int TAP_W   = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             ser_in,
  output logic             ser_out,
  output logic [TAP_W-1:0] taps
);
  logic [CHAIN_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (shift_en) sr <= {ser_in, sr[CHAIN_W-1:1]};
  end

  assign ser_out = sr[0];
  assign taps    = sr[TAP_W-1:0];

  // R2: contents frozen whenever shifting is off
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(sr));
endmodule

// File: rtl/sog_func.sv
module sog_func #(
  parameter int NIN   = 4,
  parameter int SEL_W = 3,
  parameter int NOPS  = 3
) (
  input  logic [NIN-1:0]        din,
  input  logic                  q,
  input  logic [NOPS*SEL_W-1:0] sel,
  output logic                  f
);
  localparam int NSRC = NIN + 4;

  logic [NSRC-1:0] src;
  logic [NOPS-1:0] op;

  assign src = {1'b1, 1'b0, ~q, q, din};

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    assign op[k] = src[sel[k*SEL_W +: SEL_W]];
  end

  assign f = op[0] ? op[1] : op[2];
endmodule

// File: rtl/sog_route.sv
module sog_route import sog_pkg::*; #(
  parameter int NDIR_P = 4,
  parameter int RT_WP  = 2
) (
  input  logic [NDIR_P-1:0]       din,
  input  logic                    f,
  input  logic                    q,
  input  logic [NDIR_P*RT_WP-1:0] sel,
  output logic [NDIR_P-1:0]       dout
);
  for (genvar d = 0; d < NDIR_P; d++) begin : g_dir
    route_e code;
    assign code = route_e'(sel[d*RT_WP +: RT_WP]);
    always_comb begin
      unique case (code)
        RT_FUNC: dout[d] = f;
        RT_REG:  dout[d] = q;
        RT_OPP:  dout[d] = din[(d+2) % NDIR_P];
        RT_CW:   dout[d] = din[(d+1) % NDIR_P];
        default: dout[d] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/sog_cell.sv
module sog_cell import sog_pkg::*; (
  input  logic clk,
  input  logic rst,
  input  logic cfg_en,
  input  logic cfg_in,
  output logic cfg_out,
  input  logic in_n,
  input  logic in_e,
  input  logic in_s,
  input  logic in_w,
  output logic out_n,
  output logic out_e,
  output logic out_s,
  output logic out_w
);
  logic [NDIR-1:0]   din;
  logic [NDIR-1:0]   dout;
  logic [USED_W-1:0] cfg;
  logic              f;
  logic              q;
  logic              tog, ce, clr_en, clr_hit;

  assign din = {in_w, in_s, in_e, in_n};

  sog_cfg_chain #(.CHAIN_W(CFG_W), .TAP_W(USED_W)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_en (cfg_en),
    .ser_in   (cfg_in),
    .ser_out  (cfg_out),
    .taps     (cfg)
  );

  sog_func #(.NIN(NDIR), .SEL_W(SEL_W), .NOPS(NOPS)) u_func (
    .din (din),
    .q   (q),
    .sel (cfg[OPF_W-1:0]),
    .f   (f)
  );

  sog_route #(.NDIR_P(NDIR), .RT_WP(RT_W)) u_route (
    .din  (din),
    .f    (f),
    .q    (q),
    .sel  (cfg[RT_LSB +: RTF_W]),
    .dout (dout)
  );

  assign tog     = cfg[TOG_BIT];
  assign ce      = cfg[CE_BIT];
  assign clr_en  = cfg[CLR_BIT];
  assign clr_hit = clr_en & in_w;

  // priority: reset, configuration hold, clear, enabled load
  always_ff @(posedge clk) begin
    if (rst)            q <= 1'b0;
    else if (!cfg_en) begin
      if (clr_hit)      q <= 1'b0;
      else if (ce)      q <= tog ? (q ^ f) : f;
    end
  end

  assign out_n = dout[0];
  assign out_e = dout[1];
  assign out_s = dout[2];
  assign out_w = dout[3];

  // R9: reset leaves the flip-flop at zero
  p_rst_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !q);

  // R8: shifting freezes the data flip-flop
  p_cfg_hold_q_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> $stable(q));

  // R7: enabled clear from the west input wins over load
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && clr_en && in_w) |=> !q);

  // R6: no enable and no clear means hold
  p_ce_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && !ce && !clr_hit) |=> $stable(q));
endmodule

// File: tb/test_sog_cell.sv
module test_sog_cell;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, cfg_en, cfg_in;
  logic cfg_out;
  logic [3:0] ins;
  logic out_n, out_e, out_s, out_w;
  int nchk = 0;
  int nerr = 0;
  logic [23:0] cur;
  bit cur_valid = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sog_cell i_sog_cell (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_in(cfg_in), .cfg_out(cfg_out),
    .in_n(ins[0]), .in_e(ins[1]), .in_s(ins[2]), .in_w(ins[3]),
    .out_n(out_n), .out_e(out_e), .out_s(out_s), .out_w(out_w)
  );

  function automatic logic [23:0] mk(int o0, int o1, int o2, int rn, int re,
                                     int rs, int rw, int tg, int ce, int cl, int rsv);
    logic [23:0] w;
    w = '0;
    w[2:0] = 3'(o0); w[5:3] = 3'(o1); w[8:6] = 3'(o2);
    w[10:9] = 2'(rn); w[12:11] = 2'(re); w[14:13] = 2'(rs); w[16:15] = 2'(rw);
    w[17] = 1'(tg); w[18] = 1'(ce); w[19] = 1'(cl); w[23:20] = 4'(rsv);
    return w;
  endfunction

  function automatic logic fsrc(int c, logic [3:0] d, logic qv);
    case (c)
      0: return d[0];
      1: return d[1];
      2: return d[2];
      3: return d[3];
      4: return qv;
      5: return ~qv;
      6: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [3:0] rexp(int c0, int c1, int c2, int c3,
                                      logic [3:0] d, logic fv, logic qv);
    logic [3:0] r;
    int cs[4];
    cs[0] = c0; cs[1] = c1; cs[2] = c2; cs[3] = c3;
    for (int k = 0; k < 4; k++) begin
      case (cs[k])
        0: r[k] = fv;
        1: r[k] = qv;
        2: r[k] = d[(k+2)%4];
        default: r[k] = d[(k+1)%4];
      endcase
    end
    return r;
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic load(input logic [23:0] w);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (cur_valid) chk("R1 R10 serial readback", {3'b0, cfg_out}, {3'b0, cur[i]});
      cfg_en = 1'b1;
      cfg_in = w[i];
    end
    @(negedge clk);
    cfg_en = 1'b0;
    cfg_in = 1'b0;
    cur = w;
    cur_valid = 1;
  endtask

  task automatic set_q(input logic v);
    ins = 4'b0;
    load(mk(7, v ? 7 : 6, 6, 1, 0, 0, 0, 0, 1, 0, 0));
    @(negedge clk);
    chk("R6 load q", {3'b0, out_n}, {3'b0, v});
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    nerr++;
    $display("FAIL watchdog act=running exp=finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_en = 1'b0; cfg_in = 1'b0; ins = 4'b0;
    repeat (3) @(negedge clk);
    // R9 reset state: load under reset, q must read zero
    load(mk(7, 7, 6, 1, 0, 0, 0, 0, 1, 0, 0));
    rst = 1'b0;
    #1 chk("R9 reset state", {3'b0, out_n}, 4'b0);
    @(negedge clk);
    chk("R6 enabled load", {3'b0, out_n}, 4'b1);
    // R9: one-cycle reset keeps configuration
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1 chk("R9 q cleared", {3'b0, out_n}, 4'b0);
    @(negedge clk);
    chk("R9 config kept", {3'b0, out_n}, 4'b1);
    // R10: reserved bits have no effect
    load(mk(7, 7, 6, 1, 1, 0, 0, 0, 1, 0, 4'hF));
    #1 chk("R10 reserved ignored", {2'b0, out_e, out_n}, 4'b0011);

    // R3 R4: exhaustive operand sweep for both q values
    for (int qv = 0; qv < 2; qv++) begin
      set_q(1'(qv));
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++)
          for (int c = 0; c < 8; c++) begin
            load(mk(a, b, c, 0, 1, 0, 0, 0, 0, 0, (a ^ b ^ c) & 15));
            for (int v = 0; v < 16; v++) begin
              logic fe;
              ins = 4'(v);
              fe = fsrc(a, 4'(v), 1'(qv)) ? fsrc(b, 4'(v), 1'(qv)) : fsrc(c, 4'(v), 1'(qv));
              #1 chk("R3 R4 function", {3'b0, out_n}, {3'b0, fe});
              chk("R5 reg route", {3'b0, out_e}, {3'b0, 1'(qv)});
              @(negedge clk);
            end
          end
    end

    // R5: output selector sweep, f = north input
    for (int qv = 0; qv < 2; qv++) begin
      set_q(1'(qv));
      for (int k = 0; k < 4; k++)
        for (int rot = 0; rot < 2; rot++) begin
          int c0, c1, c2, c3;
          c0 = k; c1 = (k + rot) % 4; c2 = (k + 2*rot) % 4; c3 = (k + 3*rot) % 4;
          load(mk(7, 0, 6, c0, c1, c2, c3, 0, 0, 0, 0));
          for (int v = 0; v < 16; v++) begin
            ins = 4'(v);
            #1 chk("R5 output select", {out_w, out_s, out_e, out_n},
                   rexp(c0, c1, c2, c3, 4'(v), ins[0], 1'(qv)));
            @(negedge clk);
          end
        end
    end

    // R6: toggle mode with f = 1 alternates, with f = 0 holds
    set_q(1'b0);
    load(mk(7, 7, 6, 1, 0, 0, 0, 1, 1, 0, 0));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R6 toggle", {3'b0, out_n}, {3'b0, 1'((i + 1) % 2)});
    end
    set_q(1'b1);
    load(mk(7, 6, 6, 1, 0, 0, 0, 1, 1, 0, 0));
    repeat (2) @(negedge clk);
    chk("R6 toggle f0 hold", {3'b0, out_n}, 4'b1);
    // R6: enable off holds
    set_q(1'b0);
    load(mk(7, 7, 6, 1, 0, 0, 0, 0, 0, 0, 0));
    repeat (3) @(negedge clk);
    chk("R6 ce off hold", {3'b0, out_n}, 4'b0);

    // R7: clear with enable on and off, and clear disabled
    set_q(1'b1);
    load(mk(7, 7, 6, 1, 0, 0, 0, 0, 1, 1, 0));
    @(negedge clk);
    chk("R7 no clear when west low", {3'b0, out_n}, 4'b1);
    ins = 4'b1000;
    #1 chk("R7 before edge", {3'b0, out_n}, 4'b1);
    @(negedge clk);
    chk("R7 clear over load", {3'b0, out_n}, 4'b0);
    set_q(1'b1);
    load(mk(7, 7, 6, 1, 0, 0, 0, 0, 0, 1, 0));
    ins = 4'b1000;
    @(negedge clk);
    chk("R7 clear with ce off", {3'b0, out_n}, 4'b0);
    set_q(1'b1);
    load(mk(7, 7, 6, 1, 0, 0, 0, 0, 0, 0, 0));
    ins = 4'b1000;
    repeat (2) @(negedge clk);
    chk("R7 clear disabled", {3'b0, out_n}, 4'b1);

    // R8: shift collides with pending clear and zero load
    set_q(1'b1);
    ins = 4'b1000;
    load(mk(7, 6, 6, 1, 0, 0, 0, 0, 1, 1, 0));
    #1 chk("R8 q held through shift", {3'b0, out_n}, 4'b1);
    @(negedge clk);
    chk("R8 clear after shift", {3'b0, out_n}, 4'b0);
    // R8 R9: reset held through a whole load
    set_q(1'b1);
    rst = 1'b1;
    load(mk(7, 6, 6, 1, 0, 0, 0, 0, 0, 0, 4'h5));
    rst = 1'b0;
    #1 chk("R9 reset during shift", {3'b0, out_n}, 4'b0);
    // R2: configuration unchanged while idle with busy inputs
    for (int v = 0; v < 8; v++) begin
      ins = 4'(v * 3);
      rst = 1'(v % 2);
      @(negedge clk);
    end
    rst = 1'b0;
    // readback of the idle configuration checks R2
    load(mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    load(mk(1, 2, 3, 3, 2, 1, 0, 1, 0, 1, 4'h9));

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule